// File: doc/BRIEF.md
# Store Queue with Writeback Pointer

This block buffers store operations between the point where they enter the pipeline and the point where their writes reach the data cache. Entries live in a circular ring. Each one holds an address, a byte size, the store data, the sequence number it was given, and three state bits: eligible to write, committed and completed. Three ring pointers split the ring into regions: completed-or-in-flight stores between head and the writeback pointer, committed stores waiting for the cache between the writeback pointer and the first speculative entry, and speculative stores up to the tail.

A store is allocated at the tail. Its address, size and data are filled in later through an indexed write port. A commit with a sequence number makes every older store eligible. The writeback pointer then walks forward and issues one cache write per cycle while the cache is not blocked. A slot is released only once the cache reports that its write has completed. Completions may arrive out of order, and the head moves over completed slots in ring order. A squash removes the speculative stores younger than a given sequence number by pulling the tail back.

Top module: `store_queue`

## Requirements
- R1: After reset the queue is empty: `req_valid` is 0, `stores_to_wb` is 0, `full` is 0 and `alloc_idx` is 0.
- R2: An allocation accepted at a clock edge takes slot `alloc_idx`, and `alloc_idx` then moves to the next slot modulo DEPTH. An allocation requested while `full` is 1, or while `squash_valid` is 1, is ignored and leaves `alloc_idx` unchanged.
- R3: `full` is 1 exactly when the number of occupied slots is at least DEPTH-1.
- R4: A write on the indexed port stores address, size and data in that slot with no error path. The values present when the store is issued (the last write) are the ones carried by the request.
- R5: A commit with sequence number S marks every live, uncommitted store whose sequence number is below S as committed and eligible. At the same edge, `stores_to_wb` grows by the number of stores marked.
- R6: A request is issued only for the slot at the writeback pointer, only if that store is eligible and not completed, and only if `cache_blocked` was 0 at the deciding edge. `req_valid` rises one edge after the decision. At most one request goes out per cycle, in allocation order, and `stores_to_wb` drops by one at the same edge.
- R7: A slot is released only after `done_valid` reports its index. Completions may come in any order, and the head advances past a completed slot only when every older slot has been released.
- R8: A squash with sequence number S removes every live, uncommitted store with a sequence number above S. `alloc_idx` moves back to the oldest removed slot on the next edge, and removed stores are never issued. A squash overrides a commit or an allocation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a store at the tail |
| alloc_seq | input | SEQW | Sequence number of the allocated store |
| alloc_idx | output | IW | Slot the next allocation takes |
| wr_valid | input | 1 | Write address, size and data into a slot |
| wr_idx | input | IW | Slot written |
| wr_addr | input | AW | Store address |
| wr_size | input | SZW | Store size in bytes |
| wr_data | input | DW | Store data |
| commit_valid | input | 1 | Commit stores older than `commit_seq` |
| commit_seq | input | SEQW | Commit boundary |
| squash_valid | input | 1 | Remove stores younger than `squash_seq` |
| squash_seq | input | SEQW | Squash boundary |
| cache_blocked | input | 1 | Data cache cannot accept a write |
| done_valid | input | 1 | A cache write has completed |
| done_idx | input | IW | Slot whose write completed |
| req_valid | output | 1 | Write request toward the cache |
| req_idx | output | IW | Slot of the request |
| req_addr | output | AW | Request address |
| req_size | output | SZW | Request size |
| req_data | output | DW | Request data |
| stores_to_wb | output | IW+1 | Committed stores not yet issued |
| full | output | 1 | Queue full |

## Verification
The properties assume that sequence numbers rise with allocation order and do not wrap inside the live window. They also assume that squash only names speculative stores, and that each issued slot is reported done exactly once. The stimulus follows these rules. It draws sequence numbers from a single increasing counter, and it picks squash points only among uncommitted stores. Completions come only from a list of issued slots, each removed once reported. Allocation is attempted only while `full` reads 0, except in the one directed case that checks an ignored allocation.

// File: rtl/sq_pkg.sv
package sq_pkg;
  typedef struct packed {
    logic can_wb;
    logic committed;
    logic completed;
  } sq_flags_t;

  function automatic int ring_bits(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/sq_entry_ram.sv
module sq_entry_ram
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int IW   = ring_bits(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/sq_flag_bank.sv
module sq_flag_bank
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQW  = 16,
  localparam int IW   = ring_bits(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_we,
  input  logic [IW-1:0]    alloc_at,
  input  logic [SEQW-1:0]  alloc_seq,
  input  logic [DEPTH-1:0] live,
  input  logic             commit_en,
  input  logic [SEQW-1:0]  commit_seq,
  input  logic             squash_en,
  input  logic [SEQW-1:0]  squash_seq,
  input  logic             done_en,
  input  logic [IW-1:0]    done_at,
  output logic [DEPTH-1:0] can_wb,
  output logic [DEPTH-1:0] completed,
  output logic [PW-1:0]    commit_n,
  output logic [PW-1:0]    squash_n
);
  logic [DEPTH-1:0] commit_hit, squash_hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    sq_flags_t       fl_q;
    logic [SEQW-1:0] seq_q;

    assign commit_hit[i] = commit_en & live[i] & ~fl_q.committed & (seq_q < commit_seq);
    assign squash_hit[i] = squash_en & live[i] & ~fl_q.committed & (seq_q > squash_seq);

    always_ff @(posedge clk) begin
      if (rst) begin
        fl_q <= '0;
      end else if (alloc_we && alloc_at == IW'(i)) begin
        fl_q <= '0;
      end else begin
        if (commit_hit[i]) begin
          fl_q.can_wb    <= 1'b1;
          fl_q.committed <= 1'b1;
        end
        if (done_en && done_at == IW'(i)) fl_q.completed <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_we && alloc_at == IW'(i)) seq_q <= alloc_seq;
    end

    assign can_wb[i]    = fl_q.can_wb;
    assign completed[i] = fl_q.completed;
  end

  assign commit_n = PW'($countones(commit_hit));
  assign squash_n = PW'($countones(squash_hit));
endmodule

// File: rtl/store_queue.sv
module store_queue
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int SZW   = 4,
  parameter int SEQW  = 16,
  localparam int IW   = ring_bits(DEPTH),
  localparam int PW   = IW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_valid,
  input  logic [SEQW-1:0] alloc_seq,
  output logic [IW-1:0]   alloc_idx,
  input  logic            wr_valid,
  input  logic [IW-1:0]   wr_idx,
  input  logic [AW-1:0]   wr_addr,
  input  logic [SZW-1:0]  wr_size,
  input  logic [DW-1:0]   wr_data,
  input  logic            commit_valid,
  input  logic [SEQW-1:0] commit_seq,
  input  logic            squash_valid,
  input  logic [SEQW-1:0] squash_seq,
  input  logic            cache_blocked,
  input  logic            done_valid,
  input  logic [IW-1:0]   done_idx,
  output logic            req_valid,
  output logic [IW-1:0]   req_idx,
  output logic [AW-1:0]   req_addr,
  output logic [SZW-1:0]  req_size,
  output logic [DW-1:0]   req_data,
  output logic [PW-1:0]   stores_to_wb,
  output logic            full
);
  localparam int EW = AW + SZW + DW;

  logic [PW-1:0]    head_q, tail_q, wb_q, stwb_q, occ;
  logic [PW-1:0]    commit_n, squash_n;
  logic [IW-1:0]    head_idx, wb_idx;
  logic [DEPTH-1:0] live, can_wb, completed;
  logic             alloc_ok, commit_ok, issue_ok, head_free;
  logic [EW-1:0]    ram_rd;

  assign head_idx  = head_q[IW-1:0];
  assign wb_idx    = wb_q[IW-1:0];
  assign alloc_idx = tail_q[IW-1:0];
  assign occ       = tail_q - head_q;
  assign full      = occ >= PW'(DEPTH - 1);

  assign alloc_ok  = alloc_valid & ~full & ~squash_valid;
  assign commit_ok = commit_valid & ~squash_valid;
  assign issue_ok  = (wb_q != tail_q) & can_wb[wb_idx] & ~completed[wb_idx] & ~cache_blocked;
  assign head_free = (head_q != tail_q) & completed[head_idx];

  // slot i is live when its distance from head is inside the occupancy
  for (genvar i = 0; i < DEPTH; i++) begin : g_live
    logic [IW-1:0] rel;
    assign rel     = IW'(i) - head_idx;
    assign live[i] = {1'b0, rel} < occ;
  end

  sq_flag_bank #(.DEPTH(DEPTH), .SEQW(SEQW)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .alloc_we  (alloc_ok),
    .alloc_at  (alloc_idx),
    .alloc_seq (alloc_seq),
    .live      (live),
    .commit_en (commit_ok),
    .commit_seq(commit_seq),
    .squash_en (squash_valid),
    .squash_seq(squash_seq),
    .done_en   (done_valid),
    .done_at   (done_idx),
    .can_wb    (can_wb),
    .completed (completed),
    .commit_n  (commit_n),
    .squash_n  (squash_n)
  );

  // payload storage, synchronous read at the writeback pointer
  sq_entry_ram #(.DEPTH(DEPTH), .W(EW)) u_ram (
    .clk  (clk),
    .we   (wr_valid),
    .waddr(wr_idx),
    .wdata({wr_addr, wr_size, wr_data}),
    .raddr(wb_idx),
    .rdata(ram_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q    <= '0;
      tail_q    <= '0;
      wb_q      <= '0;
      stwb_q    <= '0;
      req_valid <= 1'b0;
      req_idx   <= '0;
    end else begin
      if (squash_valid)  tail_q <= tail_q - squash_n;
      else if (alloc_ok) tail_q <= tail_q + PW'(1);
      if (head_free) head_q <= head_q + PW'(1);
      if (issue_ok)  wb_q   <= wb_q + PW'(1);
      stwb_q    <= stwb_q + commit_n - {{(PW-1){1'b0}}, issue_ok};
      req_valid <= issue_ok;
      if (issue_ok) req_idx <= wb_idx;
    end
  end

  assign {req_addr, req_size, req_data} = ram_rd;
  assign stores_to_wb = stwb_q;
endmodule

// File: rtl/sq_checker.sv
module sq_checker
  import sq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IW   = ring_bits(DEPTH),
  localparam int PW   = IW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          alloc_valid,
  input logic          squash_valid,
  input logic          cache_blocked,
  input logic          full,
  input logic [IW-1:0] alloc_idx,
  input logic          req_valid,
  input logic [IW-1:0] req_idx,
  input logic [PW-1:0] stores_to_wb
);
  p_no_req_when_blocked_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !$past(cache_blocked));

  p_req_in_order_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(req_valid)) |-> (req_idx == IW'($past(req_idx) + 1'b1)));

  p_full_blocks_alloc_r2: assert property (@(posedge clk) disable iff (rst)
    (full && alloc_valid && !squash_valid) |=> (alloc_idx == $past(alloc_idx)));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    stores_to_wb <= PW'(DEPTH));
endmodule

bind store_queue sq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .alloc_valid  (alloc_valid),
  .squash_valid (squash_valid),
  .cache_blocked(cache_blocked),
  .full         (full),
  .alloc_idx    (alloc_idx),
  .req_valid    (req_valid),
  .req_idx      (req_idx),
  .stores_to_wb (stores_to_wb)
);

// File: tb/sim_store_queue.sv
`timescale 1ns/1ps
module sim_store_queue;
  localparam int DEPTH = 8;
  localparam int AW = 32, DW = 64, SZW = 4, SEQW = 16;
  localparam int IW = 3, PW = 4;
  localparam int MAXK = 8192;

  logic clk = 1'b0, rst = 1'b1;
  logic alloc_valid = 0, wr_valid = 0, commit_valid = 0, squash_valid = 0;
  logic cache_blocked = 0, done_valid = 0;
  logic [SEQW-1:0] alloc_seq = '0, commit_seq = '0, squash_seq = '0;
  logic [IW-1:0] alloc_idx, wr_idx = '0, done_idx = '0, req_idx;
  logic [AW-1:0] wr_addr = '0, req_addr;
  logic [SZW-1:0] wr_size = '0, req_size;
  logic [DW-1:0] wr_data = '0, req_data;
  logic req_valid, full;
  logic [PW-1:0] stores_to_wb;

  always #2 clk = ~clk;

  store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .SZW(SZW), .SEQW(SEQW)) u0 (.*);

  int n_chk = 0, n_err = 0;
  bit finished = 0;
  int n_alloc = 0, n_com = 0, n_iss = 0, next_seq = 1;
  logic [SEQW-1:0] m_seq [MAXK];
  logic [AW-1:0]   m_addr [MAXK];
  logic [SZW-1:0]  m_size [MAXK];
  logic [DW-1:0]   m_data [MAXK];
  int pend[$];

  function automatic logic [IW-1:0] slot_of(input int k);
    return IW'(k % DEPTH);
  endfunction

  function automatic int exp_pending();
    return n_com - n_iss;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic monitor();
    if (req_valid) begin
      chk(!cache_blocked, "R6 request while cache blocked", 1, 0);
      if (n_iss >= n_com) begin
        chk(0, "R6/R8 request for uncommitted or squashed store", req_idx, 0);
      end else begin
        chk(req_idx == slot_of(n_iss) && req_addr == m_addr[n_iss] &&
            req_size == m_size[n_iss] && req_data == m_data[n_iss],
            "R4/R6 request contents", req_data, m_data[n_iss]);
        pend.push_back(n_iss);
        n_iss++;
      end
    end
  endtask

  task automatic step();
    @(negedge clk);
    monitor();
    alloc_valid = 0; wr_valid = 0; commit_valid = 0; squash_valid = 0; done_valid = 0;
  endtask

  task automatic do_alloc();
    chk(alloc_idx == slot_of(n_alloc), "R2 allocation slot", alloc_idx, slot_of(n_alloc));
    m_seq[n_alloc]  = SEQW'(next_seq);
    m_addr[n_alloc] = $urandom;
    m_size[n_alloc] = SZW'($urandom_range(1, 8));
    m_data[n_alloc] = {$urandom, $urandom};
    alloc_valid = 1; alloc_seq = SEQW'(next_seq);
    wr_valid = 1; wr_idx = slot_of(n_alloc);
    wr_addr = m_addr[n_alloc]; wr_size = m_size[n_alloc]; wr_data = m_data[n_alloc];
    next_seq++; n_alloc++;
  endtask

  task automatic do_rewrite(input int k);
    m_addr[k] = $urandom; m_size[k] = SZW'($urandom_range(1, 8)); m_data[k] = {$urandom, $urandom};
    wr_valid = 1; wr_idx = slot_of(k);
    wr_addr = m_addr[k]; wr_size = m_size[k]; wr_data = m_data[k];
  endtask

  task automatic do_commit(input int j);
    commit_valid = 1;
    commit_seq = (j < n_alloc) ? m_seq[j] : SEQW'(next_seq);
    n_com = j;
  endtask

  task automatic do_squash(input int j);
    squash_valid = 1; squash_seq = m_seq[j] - 1'b1; n_alloc = j;
  endtask

  task automatic done_k(input int k);
    foreach (pend[p]) if (pend[p] == k) begin pend.delete(p); break; end
    done_valid = 1; done_idx = slot_of(k);
  endtask

  task automatic done_random();
    if (pend.size() > 0) begin
      int p = $urandom_range(0, pend.size() - 1);
      done_valid = 1; done_idx = slot_of(pend[p]);
      pend.delete(p);
    end
  endtask

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) step();
    rst = 0;
    step();
    // R1 reset state
    chk(req_valid == 0, "R1 req_valid after reset", req_valid, 0);
    chk(stores_to_wb == 0, "R1 stores_to_wb after reset", stores_to_wb, 0);
    chk(full == 0, "R1 full after reset", full, 0);
    chk(alloc_idx == 0, "R1 alloc_idx after reset", alloc_idx, 0);

    // R3 fill with cache blocked
    cache_blocked = 1;
    for (int i = 0; i < DEPTH - 2; i++) begin do_alloc(); step(); end
    chk(full == 0, "R3 not full at DEPTH-2", full, 0);
    do_alloc(); step();
    chk(full == 1, "R3 full at DEPTH-1", full, 1);
    // R2 allocation ignored when full
    alloc_valid = 1; alloc_seq = SEQW'(next_seq); step(); step();
    chk(alloc_idx == slot_of(n_alloc), "R2 ignored allocation when full", alloc_idx, slot_of(n_alloc));

    // R4 rewrite before commit; R5 commit three
    do_rewrite(0); step();
    do_commit(3); step();
    chk(stores_to_wb == 3, "R5 stores_to_wb after commit", stores_to_wb, 3);
    repeat (4) step();
    chk(stores_to_wb == 3 && n_iss == 0, "R6 no issue while blocked", stores_to_wb, 3);

    // R6 release
    cache_blocked = 0;
    repeat (6) step();
    chk(n_iss == 3, "R6 issued count", n_iss, 3);
    chk(stores_to_wb == 0, "R6 stores_to_wb after issue", stores_to_wb, 0);
    chk(full == 1, "R7 issued but not done keeps slots", full, 1);

    // R7 out-of-order completion
    done_k(2); step();
    repeat (4) step();
    chk(full == 1, "R7 younger completion does not free head", full, 1);
    done_k(0); step();
    done_k(1); step();
    repeat (5) step();
    chk(full == 0, "R7 head released after in-order completion", full, 0);

    // R8 squash
    do_alloc(); step();
    do_alloc(); step();
    do_rewrite(3); step();
    do_squash(5); step();
    chk(alloc_idx == slot_of(5), "R8 tail rewinds on squash", alloc_idx, slot_of(5));
    do_commit(n_alloc); step();
    repeat (6) step();
    chk(n_iss == 5, "R8 only surviving stores issued", n_iss, 5);
    chk(stores_to_wb == 0, "R5 count drained", stores_to_wb, 0);
    while (pend.size() > 0) begin done_random(); step(); end
    repeat (5) step();
    chk(full == 0, "R7 all released", full, 0);

    // constrained random phase
    for (int c = 0; c < 4000; c++) begin
      int r = $urandom_range(0, 99);
      cache_blocked = ($urandom_range(0, 99) < 30);
      if (r < 8 && n_alloc > n_com) begin
        do_squash($urandom_range(n_com, n_alloc - 1));
      end else begin
        if ($urandom_range(0, 99) < 20) do_commit($urandom_range(n_com, n_alloc));
        if (!full && $urandom_range(0, 99) < 50) do_alloc();
        else if (n_alloc > n_com && $urandom_range(0, 99) < 20)
          do_rewrite($urandom_range(n_com, n_alloc - 1));
      end
      if ($urandom_range(0, 99) < 40) done_random();
      step();
      chk(stores_to_wb == PW'(exp_pending()), "R5/R6 stores_to_wb tracking", stores_to_wb, exp_pending());
    end

    // drain
    cache_blocked = 0;
    do_commit(n_alloc); step();
    for (int c = 0; c < 40; c++) begin done_random(); step(); end
    while (pend.size() > 0) begin done_random(); step(); end
    repeat (5) step();
    chk(n_iss == n_alloc, "R6 every committed store issued", n_iss, n_alloc);
    chk(stores_to_wb == 0, "R5 final count", stores_to_wb, 0);
    chk(full == 0, "R7 final release", full, 0);
    chk(alloc_idx == slot_of(n_alloc), "R2 final tail", alloc_idx, slot_of(n_alloc));

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule